// File: doc/BRIEF.md
# Timing-Error Stall Elision Controller

This controller sits beside the hazard logic of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Its input is an error flag raised by the execute-to-memory register when a late-arriving result has been caught by the shadow latch. Without this block, such an error freezes all five stages for one cycle while the corrected value is copied into the main register.

The controller checks whether the instruction in decode is independent of the faulting instruction in execute. Independent means two things. None of its operands forwards from the execute result, and it selects a different execution unit (the ALU or one particular custom accelerator). When both hold and no ordinary hazard stall is pending, the stall is dropped. The execute-to-memory register is then told to take the repaired value and also merge in the following instruction's result, so no cycle is lost. Otherwise every stage is frozen for one cycle.

When the error flag is low, the baseline hazard stalls pass straight through. Two saturating counters record how many errors were absorbed and how many cost a full stall.

Top module: `tmg_stall_elider`

## Requirements
- R1: With `err_i` low, `stall_o` equals `base_stall_i` and `en_o` equals its complement. `exmem_fix_o` and `exmem_merge_o` are 0, and neither counter changes.
- R2: With `err_i` high and a valid decode instruction, a full stall results: `stall_o` all ones, `en_o` all zeros, `exmem_fix_o` 1, `exmem_merge_o` 0. This applies when any operand's 2-bit forwarding code (operand k at bits [2k+1:2k]) equals 1, meaning "take the value from the instruction in execute".
- R3: With `err_i` high and a valid decode instruction, a full stall also results when `id_unit_i` and `ex_unit_i` share a set bit. The unit selects are one-hot: bit 0 is the ALU and bit k is accelerator k.
- R4: With `err_i` high, no base stall, and an independent valid decode instruction, the stall is elided: `stall_o` all zeros, `en_o` all ones, `exmem_fix_o` 1, `exmem_merge_o` 1. Forwarding codes 0, 2 and 3 do not make an instruction dependent.
- R5: With `err_i` high and `id_valid_i` low (a bubble in decode), the stall is elided whatever the forwarding and unit selects show, provided no base stall is pending.
- R6: With `err_i` high and any `base_stall_i` bit set, a full stall results, even for an independent instruction.
- R7: `elided_cnt_o` rises by one in the cycle after each elided error and holds at its all-ones maximum.
- R8: `stalled_cnt_o` rises by one in the cycle after each full stall caused by an error and holds at its all-ones maximum.
- R9: A synchronous reset clears both counters to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_i | input | 1 | Timing error flagged by the execute-to-memory register |
| base_stall_i | input | NSTAGE | Stall requests from the baseline hazard logic, bit 0 = fetch |
| id_valid_i | input | 1 | Decode stage holds a real instruction |
| fwd_sel_i | input | NSRC*FWD_W | Forwarding codes of the decode instruction's operands |
| id_unit_i | input | NUNIT | One-hot unit select of the decode instruction |
| ex_unit_i | input | NUNIT | One-hot unit select of the execute instruction |
| stall_o | output | NSTAGE | Per-stage stall |
| en_o | output | NSTAGE | Per-stage register enable |
| exmem_fix_o | output | 1 | Execute-to-memory register loads the repaired value |
| exmem_merge_o | output | 1 | Execute-to-memory register also captures the overlapped instruction |
| elided_cnt_o | output | CNT_W | Saturating count of absorbed errors |
| stalled_cnt_o | output | CNT_W | Saturating count of errors that froze the pipe |

## Verification
The assertions rely on the unit selects being one-hot or zero and on each forwarding field holding one of the four defined codes. They also rely on the error flag being a level that is sampled once per cycle. The scoreboard drives only one-hot unit patterns (including the all-zero case for an idle execute stage) and legal codes. It changes inputs only on the falling edge, so every combinational decision is stable at the sampling edge. Long runs of identical error events push both counters past their limit to exercise saturation.

// File: rtl/tse_pkg.sv
package tse_pkg;
  localparam int NUM_STAGES  = 5;
  localparam int STG_FETCH   = 0;
  localparam int STG_DECODE  = 1;
  localparam int STG_EXEC    = 2;
  localparam int STG_MEM     = 3;
  localparam int STG_WB      = 4;
  // forwarding code: operand comes from the instruction now in execute
  localparam int FWD_CODE_EX = 1;

  typedef enum logic [1:0] {
    EVT_NONE  = 2'd0,
    EVT_ELIDE = 2'd1,
    EVT_FULL  = 2'd2
  } err_evt_e;
endpackage

// File: rtl/tse_dep_check.sv
module tse_dep_check #(
  parameter int NSRC  = 2,
  parameter int FWD_W = 2,
  parameter int NUNIT = 4
) (
  input  logic                   id_valid_i,
  input  logic [NSRC*FWD_W-1:0]  fwd_sel_i,
  input  logic [NUNIT-1:0]       id_unit_i,
  input  logic [NUNIT-1:0]       ex_unit_i,
  output logic                   indep_o
);
  import tse_pkg::*;

  logic [NSRC-1:0]  src_hit;
  logic [NUNIT-1:0] unit_share;
  logic             data_dep;
  logic             res_dep;

  // one comparator per source operand
  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign src_hit[s] = (fwd_sel_i[s*FWD_W +: FWD_W] == FWD_W'(FWD_CODE_EX));
  end

  // one overlap term per execution unit
  for (genvar u = 0; u < NUNIT; u++) begin : g_unit
    assign unit_share[u] = id_unit_i[u] & ex_unit_i[u];
  end

  assign data_dep = |src_hit;
  assign res_dep  = |unit_share;
  assign indep_o  = !id_valid_i || (!data_dep && !res_dep);
endmodule

// File: rtl/tse_stall_mux.sv
module tse_stall_mux #(
  parameter int NSTAGE = 5
) (
  input  logic              err_i,
  input  logic              indep_i,
  input  logic [NSTAGE-1:0] base_stall_i,
  output logic [NSTAGE-1:0] stall_o,
  output logic [NSTAGE-1:0] en_o,
  output logic              fix_o,
  output logic              merge_o,
  output tse_pkg::err_evt_e evt_o
);
  import tse_pkg::*;

  logic base_any;
  logic elide;
  logic freeze;

  assign base_any = |base_stall_i;
  assign elide    = err_i && indep_i && !base_any;
  assign freeze   = err_i && !elide;

  for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
    assign stall_o[g] = freeze | base_stall_i[g];
    assign en_o[g]    = ~stall_o[g];
  end

  assign fix_o   = err_i;
  assign merge_o = elide;

  always_comb begin
    evt_o = EVT_NONE;
    if (elide)       evt_o = EVT_ELIDE;
    else if (freeze) evt_o = EVT_FULL;
  end
endmodule

// File: rtl/tse_sat_cnt.sv
module tse_sat_cnt #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst)                       cnt_o <= '0;
    else if (inc_i && cnt_o != TOP) cnt_o <= cnt_o + 1'b1;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    inc_i && cnt_o != TOP |=> cnt_o == $past(cnt_o) + 1'b1); // R7 R8
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !inc_i |=> $stable(cnt_o)); // R1
  AST_CNT_CEIL: assert property (@(posedge clk) disable iff (rst)
    cnt_o == TOP |=> cnt_o == TOP); // R8
endmodule

// File: rtl/tmg_stall_elider.sv
module tmg_stall_elider #(
  parameter int NSTAGE = 5,
  parameter int NSRC   = 2,
  parameter int FWD_W  = 2,
  parameter int NUNIT  = 4,
  parameter int CNT_W  = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  err_i,
  input  logic [NSTAGE-1:0]     base_stall_i,
  input  logic                  id_valid_i,
  input  logic [NSRC*FWD_W-1:0] fwd_sel_i,
  input  logic [NUNIT-1:0]      id_unit_i,
  input  logic [NUNIT-1:0]      ex_unit_i,
  output logic [NSTAGE-1:0]     stall_o,
  output logic [NSTAGE-1:0]     en_o,
  output logic                  exmem_fix_o,
  output logic                  exmem_merge_o,
  output logic [CNT_W-1:0]      elided_cnt_o,
  output logic [CNT_W-1:0]      stalled_cnt_o
);
  import tse_pkg::*;

  localparam int NCNT = 2;

  logic      indep;
  err_evt_e  evt;
  logic [NCNT-1:0]        cnt_inc;
  logic [NCNT*CNT_W-1:0]  cnt_bus;

  tse_dep_check #(.NSRC(NSRC), .FWD_W(FWD_W), .NUNIT(NUNIT)) u_dep (
    .id_valid_i (id_valid_i),
    .fwd_sel_i  (fwd_sel_i),
    .id_unit_i  (id_unit_i),
    .ex_unit_i  (ex_unit_i),
    .indep_o    (indep)
  );

  tse_stall_mux #(.NSTAGE(NSTAGE)) u_mux (
    .err_i        (err_i),
    .indep_i      (indep),
    .base_stall_i (base_stall_i),
    .stall_o      (stall_o),
    .en_o         (en_o),
    .fix_o        (exmem_fix_o),
    .merge_o      (exmem_merge_o),
    .evt_o        (evt)
  );

  assign cnt_inc[0] = (evt == EVT_ELIDE);
  assign cnt_inc[1] = (evt == EVT_FULL);

  for (genvar c = 0; c < NCNT; c++) begin : g_cnt
    tse_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .inc_i (cnt_inc[c]),
      .cnt_o (cnt_bus[c*CNT_W +: CNT_W])
    );
  end

  assign elided_cnt_o  = cnt_bus[0 +: CNT_W];
  assign stalled_cnt_o = cnt_bus[CNT_W +: CNT_W];

  AST_QUIET_PASS: assert property (@(posedge clk) disable iff (rst)
    !err_i |-> stall_o == base_stall_i && !exmem_fix_o && !exmem_merge_o); // R1
  AST_DATA_FREEZE: assert property (@(posedge clk) disable iff (rst)
    err_i && id_valid_i && fwd_sel_i[FWD_W-1:0] == FWD_W'(FWD_CODE_EX)
      |-> stall_o == '1 && en_o == '0); // R2
  AST_UNIT_FREEZE: assert property (@(posedge clk) disable iff (rst)
    err_i && id_valid_i && (id_unit_i & ex_unit_i) != '0 |-> stall_o == '1); // R3
  AST_FIX_ON_ERR: assert property (@(posedge clk) disable iff (rst)
    err_i |-> exmem_fix_o); // R4
  AST_MERGE_NO_STALL: assert property (@(posedge clk) disable iff (rst)
    exmem_merge_o |-> stall_o == '0 && err_i); // R4
  AST_BUBBLE_GOES: assert property (@(posedge clk) disable iff (rst)
    err_i && !id_valid_i && base_stall_i == '0 |-> exmem_merge_o); // R5
  AST_BASE_FORCES: assert property (@(posedge clk) disable iff (rst)
    err_i && base_stall_i != '0 |-> stall_o == '1 && !exmem_merge_o); // R6
  AST_SINGLE_EVT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cnt_inc)); // R7 R8
endmodule

// File: tb/tmg_stall_elider_test.sv
module tmg_stall_elider_test;
  localparam int CLK_PERIOD = 10;
  localparam int NSTAGE = 5;
  localparam int CNT_W  = 6;
  localparam int CMAX   = (1 << CNT_W) - 1;
  localparam int WDOG   = 20000;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             err_i = 1'b0;
  logic [NSTAGE-1:0] base_stall_i = '0;
  logic             id_valid_i = 1'b0;
  logic [3:0]       fwd_sel_i = '0;
  logic [3:0]       id_unit_i = '0;
  logic [3:0]       ex_unit_i = '0;
  logic [NSTAGE-1:0] stall_o, en_o;
  logic             exmem_fix_o, exmem_merge_o;
  logic [CNT_W-1:0] elided_cnt_o, stalled_cnt_o;

  tmg_stall_elider #(.NSTAGE(NSTAGE), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .err_i(err_i), .base_stall_i(base_stall_i),
    .id_valid_i(id_valid_i), .fwd_sel_i(fwd_sel_i), .id_unit_i(id_unit_i),
    .ex_unit_i(ex_unit_i), .stall_o(stall_o), .en_o(en_o),
    .exmem_fix_o(exmem_fix_o), .exmem_merge_o(exmem_merge_o),
    .elided_cnt_o(elided_cnt_o), .stalled_cnt_o(stalled_cnt_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [NSTAGE-1:0] stall;
    logic              fix;
    logic              merge;
    int                ecnt;
    int                fcnt;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int n_checks = 0;
  int n_fail   = 0;
  int m_ecnt   = 0;
  int m_fcnt   = 0;
  bit done     = 0;

  task automatic drive(input logic err, input logic [NSTAGE-1:0] base,
                       input logic [3:0] fwd, input logic idv,
                       input logic [3:0] idu, input logic [3:0] exu,
                       input string tag);
    exp_t e;
    logic dep;
    @(negedge clk);
    err_i = err; base_stall_i = base; fwd_sel_i = fwd;
    id_valid_i = idv; id_unit_i = idu; ex_unit_i = exu;
    dep = idv && (fwd[1:0] == 2'd1 || fwd[3:2] == 2'd1 || (idu & exu) != 4'd0);
    if (!err) begin
      e.stall = base; e.fix = 1'b0; e.merge = 1'b0;
    end else if (!dep && base == '0) begin
      e.stall = '0; e.fix = 1'b1; e.merge = 1'b1;
      if (m_ecnt < CMAX) m_ecnt++;
    end else begin
      e.stall = '1; e.fix = 1'b1; e.merge = 1'b0;
      if (m_fcnt < CMAX) m_fcnt++;
    end
    e.ecnt = m_ecnt; e.fcnt = m_fcnt;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // monitor: after each edge the counters reflect that cycle's event
  always @(posedge clk) begin
    if (!rst && exp_q.size() > 0) begin
      exp_t  e;
      string t;
      #1;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_checks++;
      if (stall_o !== e.stall || en_o !== ~e.stall || exmem_fix_o !== e.fix ||
          exmem_merge_o !== e.merge || int'(elided_cnt_o) != e.ecnt ||
          int'(stalled_cnt_o) != e.fcnt) begin
        n_fail++;
        $display("FAIL %s: got stall=%b en=%b fix=%b merge=%b ec=%0d fc=%0d exp stall=%b en=%b fix=%b merge=%b ec=%0d fc=%0d",
                 t, stall_o, en_o, exmem_fix_o, exmem_merge_o, elided_cnt_o, stalled_cnt_o,
                 e.stall, ~e.stall, e.fix, e.merge, e.ecnt, e.fcnt);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    n_checks++; // R9 reset state
    if (elided_cnt_o !== '0 || stalled_cnt_o !== '0 || stall_o !== '0) begin
      n_fail++;
      $display("FAIL R9: ec=%0d fc=%0d stall=%b exp 0 0 00000",
               elided_cnt_o, stalled_cnt_o, stall_o);
    end
    // R1: pass-through of baseline stalls with no error
    drive(0, 5'b00000, 4'h0, 1, 4'b0001, 4'b0001, "R1");
    drive(0, 5'b00011, 4'h1, 1, 4'b0010, 4'b0010, "R1");
    drive(0, 5'b10101, 4'h5, 0, 4'b0000, 4'b0001, "R1");
    // R2: data dependency through either operand
    drive(1, 5'b00000, 4'h1, 1, 4'b0001, 4'b0010, "R2");
    drive(1, 5'b00000, 4'h4, 1, 4'b0100, 4'b0001, "R2");
    // R3: shared unit
    drive(1, 5'b00000, 4'h0, 1, 4'b0001, 4'b0001, "R3");
    drive(1, 5'b00000, 4'h2, 1, 4'b1000, 4'b1000, "R3");
    // R4: independent, other forwarding codes harmless
    drive(1, 5'b00000, 4'hA, 1, 4'b0001, 4'b0100, "R4");
    drive(1, 5'b00000, 4'hF, 1, 4'b0010, 4'b0000, "R4");
    drive(1, 5'b00000, 4'h8, 1, 4'b0100, 4'b1000, "R4");
    // R5: bubble in decode despite conflicting selects
    drive(1, 5'b00000, 4'h5, 0, 4'b0001, 4'b0001, "R5");
    // R6: pending base stall forces a full freeze
    drive(1, 5'b00010, 4'h0, 1, 4'b0001, 4'b0010, "R6");
    drive(1, 5'b10000, 4'h0, 0, 4'b0000, 4'b0000, "R6");
    drive(0, 5'b00000, 4'h0, 1, 4'b0001, 4'b0010, "R1");
    // R7: saturate the elided counter
    for (int i = 0; i < CMAX + 6; i++)
      drive(1, 5'b00000, 4'h0, 1, 4'b0010, 4'b0001, "R7");
    // R8: saturate the full-stall counter
    for (int i = 0; i < CMAX + 6; i++)
      drive(1, 5'b00000, 4'h1, 1, 4'b0010, 4'b0001, "R8");
    drive(0, 5'b00000, 4'h0, 1, 4'b0001, 4'b0001, "R1");
    @(negedge clk);
    @(negedge clk);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < WDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected completion", cyc);
    end
    if (exp_q.size() != 0) begin
      n_checks++;
      n_fail++;
      $display("FAIL scoreboard: %0d items left, expected 0", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule